// File: doc/BRIEF.md
# Receive Width-Adapting Gearbox with Bit Slip

This block sits on the receive path between a narrow deserializer-side word stream and a wider processing datapath. Every clock it takes one narrow word, and it packs the bits into wide words. The wide width is not two or four times the narrow width, so the number of narrow words per wide word is not a whole number. A residue buffer holds the bits that are left over between words, and a one-cycle strobe marks each cycle in which a wide word is presented.

Word alignment is found by slipping. Each rising edge of a single-bit slip request throws away the oldest buffered bit, which moves the wide-word boundary one bit later in the stream. Slipping is honoured only while the slip-enable control is high. A separate control complements every received bit before it is buffered, to correct a swapped differential pair.

Top module: `rx_gearbox`

## Requirements
- R1: A synchronous active-high reset empties the buffer, clears the slip offset and the slip edge memory, and holds `word_vld` low. `word_vld` stays low in the first cycle after reset is released.
- R2: Bits are packed LSB-first. The earliest received bit not yet emitted goes to bit 0 of the next wide word, and consecutive wide words carry consecutive stretches of the stream, with no gap and no repeat.
- R3: A wide word is emitted in each cycle in which the buffered bit count reaches or passes `OUT_W`, and the count then drops by `OUT_W`. With no slips, exactly `IN_W*k/OUT_W` words come out in the first k cycles after reset, when that ratio is a whole number (200 words in 320 cycles at 40/64).
- R4: While `pol_inv` is 1, every bit of the incoming narrow word is complemented before it is buffered. While it is 0, bits pass unchanged.
- R5: With `slip_en` at 1, a 0-to-1 transition of `slip` (sampled on the clock) discards the oldest pending bit in that same cycle. After N such edges, every later wide word equals the reference stream advanced by N bits.
- R6: Holding `slip` high produces only one slip. A further slip needs `slip` to go low and then high again.
- R7: With `slip_en` at 0, `slip` has no effect: the stream alignment and the slip offset are not changed.
- R8: The slip offset counts slips modulo `OUT_W` (0 to `OUT_W`-1) and wraps from `OUT_W`-1 to 0. After `OUT_W` slips, the output is the stream advanced by exactly `OUT_W` bits.
- R9: `word_out` and `word_vld` are registered. The narrow word sampled at clock edge k contributes to a word that appears after edge k.
- R10: Elaboration stops when `IN_W` is not smaller than `OUT_W`, or when `OUT_W` is exactly 2 or 4 times `IN_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | IN_W | Narrow received word, earliest bit in bit 0 |
| pol_inv | input | 1 | 1 = complement all received bits |
| slip_en | input | 1 | 1 = honour slip requests |
| slip | input | 1 | Slip request, acting on its rising edge |
| word_out | output | OUT_W | Wide output word, earliest bit in bit 0 |
| word_vld | output | 1 | One-cycle strobe marking a new `word_out` |

## Verification
An error in the fill count shows at the ports within one wide word: the valid strobe shifts to the wrong cycle, and the packed data are misaligned by the difference. An error in the residue buffer or in the slip edge detector gives a word that differs from the stream advanced by the number of slips. The bench compares this with a bit-queue model in the first emitted word after the fault, which is at most two cycles later. An inversion or shift fault therefore fails the cycle-by-cycle comparison within one or two clocks.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
   // Width of a counter that must hold the value max_val.
   function automatic int gbx_cnt_bits(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction
endpackage

// File: rtl/gbx_polarity.sv
module gbx_polarity #(
   parameter int W = 40
) (
   input  logic         inv,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign d_out[i] = d_in[i] ^ inv;
   end
endmodule

// File: rtl/gbx_slip_edge.sv
module gbx_slip_edge #(
   parameter int OUT_W = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic slip_en,
   input  logic slip,
   output logic take
);
   localparam int OW = gbx_pkg::gbx_cnt_bits(OUT_W - 1);
   localparam logic [OW-1:0] OFS_MAX = OW'(OUT_W - 1);

   logic          slip_q;
   logic [OW-1:0] ofs_q;

   assign take = slip_en & slip & ~slip_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slip_q <= 1'b0;
         ofs_q  <= '0;
      end else begin
         slip_q <= slip;
         if (take) ofs_q <= (ofs_q == OFS_MAX) ? '0 : ofs_q + OW'(1);
      end
   end

   // R6: a held level never produces two slips in a row
   p_take_gap_r6: assert property (@(posedge clk) disable iff (rst) take |=> !take);
   // R8: offset wraps to zero after the last position
   p_ofs_wrap_r8: assert property (@(posedge clk) disable iff (rst)
      (take && ofs_q == OFS_MAX) |=> ofs_q == '0);
   // R7: with slipping disabled the offset does not move
   p_ofs_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !slip_en |=> ofs_q == $past(ofs_q));
   // R8: offset never leaves its range
   p_ofs_range_r8: assert property (@(posedge clk) disable iff (rst) ofs_q <= OFS_MAX);
endmodule

// File: rtl/gbx_pack.sv
module gbx_pack #(
   parameter int IN_W  = 40,
   parameter int OUT_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IN_W-1:0]  d_in,
   input  logic             drop,
   output logic [OUT_W-1:0] d_out,
   output logic             d_vld
);
   localparam int BUF_W = OUT_W + IN_W;
   localparam int CW    = gbx_pkg::gbx_cnt_bits(BUF_W);
   localparam logic [CW-1:0] IN_C  = CW'(IN_W);
   localparam logic [CW-1:0] OUT_C = CW'(OUT_W);

   logic [BUF_W-1:0] bits_q, merged, ext;
   logic [CW-1:0]    cnt_q, total;

   always_comb begin
      merged = bits_q | (BUF_W'(d_in) << cnt_q);
      ext    = drop ? (merged >> 1) : merged;
      total  = cnt_q + IN_C - CW'(drop);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bits_q <= '0;
         cnt_q  <= '0;
         d_out  <= '0;
         d_vld  <= 1'b0;
      end else if (total >= OUT_C) begin
         d_out  <= ext[OUT_W-1:0];
         d_vld  <= 1'b1;
         bits_q <= ext >> OUT_W;
         cnt_q  <= total - OUT_C;
      end else begin
         bits_q <= ext;
         cnt_q  <= total;
         d_vld  <= 1'b0;
      end
   end

   // R3: the residue never holds a full word once a cycle has ended
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst) cnt_q < OUT_C);
   // R3: an emitted word lowers the residue below what was added
   p_emit_drop_r3: assert property (@(posedge clk) disable iff (rst)
      d_vld |-> cnt_q < IN_C);
endmodule

// File: rtl/rx_gearbox.sv
module rx_gearbox #(
   parameter int IN_W  = 40,
   parameter int OUT_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IN_W-1:0]  rx_word,
   input  logic             pol_inv,
   input  logic             slip_en,
   input  logic             slip,
   output logic [OUT_W-1:0] word_out,
   output logic             word_vld
);
   // R10: parameter legality
   if (IN_W < 1 || IN_W >= OUT_W) begin : g_bad_order
      $error("rx_gearbox: IN_W must be at least 1 and smaller than OUT_W");
   end
   if (OUT_W == 2 * IN_W || OUT_W == 4 * IN_W) begin : g_bad_ratio
      $error("rx_gearbox: a 2x or 4x ratio does not need this gearbox");
   end

   logic [IN_W-1:0] pol_word;
   logic            take;

   gbx_polarity #(.W(IN_W)) pol_i (
      .inv   (pol_inv),
      .d_in  (rx_word),
      .d_out (pol_word)
   );

   gbx_slip_edge #(.OUT_W(OUT_W)) slip_i (
      .clk     (clk),
      .rst     (rst),
      .slip_en (slip_en),
      .slip    (slip),
      .take    (take)
   );

   gbx_pack #(.IN_W(IN_W), .OUT_W(OUT_W)) pack_i (
      .clk   (clk),
      .rst   (rst),
      .d_in  (pol_word),
      .drop  (take),
      .d_out (word_out),
      .d_vld (word_vld)
   );

   // R1: reset forces the strobe low on the following cycle
   p_vld_rst_r1: assert property (@(posedge clk) rst |=> !word_vld);
endmodule

// File: tb/rx_gearbox_tb_top.sv
module rx_gearbox_tb_top;
   localparam int IN_W  = 40;
   localparam int OUT_W = 64;

   logic             clk = 1'b0;
   logic             rst;
   logic [IN_W-1:0]  rx_word;
   logic             pol_inv, slip_en, slip;
   logic [OUT_W-1:0] word_out;
   logic             word_vld;

   int checks = 0, errors = 0, words = 0, cyc_n = 0;
   bit model_q[$];
   bit prev_slip = 1'b0;
   bit exp_vld = 1'b0;
   logic [OUT_W-1:0] exp_word = '0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rx_gearbox #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
      .clk(clk), .rst(rst), .rx_word(rx_word), .pol_inv(pol_inv),
      .slip_en(slip_en), .slip(slip), .word_out(word_out), .word_vld(word_vld)
   );

   task automatic model_step();
      if (rst) begin
         model_q.delete();
         prev_slip = 1'b0;
         exp_vld = 1'b0;
      end else begin
         for (int i = 0; i < IN_W; i++) model_q.push_back(rx_word[i] ^ pol_inv);
         if (slip_en && slip && !prev_slip) void'(model_q.pop_front());
         prev_slip = slip;
         if (model_q.size() >= OUT_W) begin
            for (int i = 0; i < OUT_W; i++) exp_word[i] = model_q.pop_front();
            exp_vld = 1'b1;
         end else exp_vld = 1'b0;
      end
   endtask

   // Called just after a negedge: drive, predict, wait one cycle, compare (R9 latency).
   task automatic cycle(input logic r, input logic inv, input logic sen, input logic sl);
      rst = r; pol_inv = inv; slip_en = sen; slip = sl;
      rx_word = IN_W'({$urandom(), $urandom()});
      model_step();
      @(negedge clk);
      cyc_n++;
      checks++;
      if (word_vld !== exp_vld) begin
         errors++;
         $display("FAIL %s/R9 word_vld actual %0b expected %0b", cur_req, word_vld, exp_vld);
      end else if (exp_vld && word_out !== exp_word) begin
         errors++;
         $display("FAIL %s/R2 word_out actual %h expected %h", cur_req, word_out, exp_word);
      end
      if (word_vld === 1'b1) words++;
   endtask

   task automatic pulse_slip(input logic sen, input int n);
      for (int k = 0; k < n; k++) begin
         cycle(1'b0, 1'b0, sen, 1'b1);
         cycle(1'b0, 1'b0, sen, 1'b0);
         cycle(1'b0, 1'b0, sen, 1'b0);
      end
   endtask

   initial begin
      rst = 1'b1; pol_inv = 1'b0; slip_en = 1'b0; slip = 1'b0; rx_word = '0;
      @(negedge clk);
      // R1: reset holds the strobe low
      cur_req = "R1";
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, 1'b0, 1'b0);
      checks++;
      if (word_vld !== 1'b0) begin
         errors++; $display("FAIL R1 word_vld after reset actual %0b expected 0", word_vld);
      end
      // R3: cadence from an empty buffer, 319 more cycles -> 320 in total
      cur_req = "R3";
      words = 0;
      for (int i = 0; i < 319; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
      checks++;
      if (words != IN_W * 320 / OUT_W) begin
         errors++; $display("FAIL R3 word count actual %0d expected %0d", words, IN_W * 320 / OUT_W);
      end
      // R4: polarity inversion
      cur_req = "R4";
      for (int i = 0; i < 50; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0);
      // R5: isolated slip edges
      cur_req = "R5";
      pulse_slip(1'b1, 5);
      for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0);
      // R6: held level slips once
      cur_req = "R6";
      for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0);
      // R7: slips ignored while disabled
      cur_req = "R7";
      pulse_slip(1'b0, 10);
      for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
      // R8: full lap of the offset plus a few more
      cur_req = "R8";
      pulse_slip(1'b1, OUT_W + 3);
      for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 1'b1, 1'b0);
      // R1: reset mid-stream, then R2 packing resumes from an empty buffer
      cur_req = "R1";
      cycle(1'b1, 1'b0, 1'b1, 1'b0);
      cycle(1'b1, 1'b0, 1'b1, 1'b0);
      cur_req = "R2";
      for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule